// File: doc/BRIEF.md
# Sleep-Pin Low-Power Mode Controller

This block is the device-side state keeper for a self-refreshing memory. It watches an active-low sleep request pin, the chip enable and the sleep-mode selection bit of the configuration register, and it decides which power state the memory is in. After power-up, and again after leaving deep power-down, it runs a reinitialization window measured in microseconds. Reads and writes are held off during that window and in both low-power modes.

A low level on the sleep pin only counts once it has lasted longer than a qualifying time. When it does, the selection bit picks one of two modes. Partial refresh keeps the data, and the pin returning high releases the array at once. Deep power-down loses the data, and leaving it restarts reinitialization. When the configuration register has been loaded through the software sequence, a lock is set. From then until the next reset, partial refresh follows the selection bit directly and no longer follows the pin.

All timing comes from one shared microsecond timer driven by a clock-divider parameter. The inputs are taken to be already synchronous to `clk`. The outputs are the current mode code, a ready flag and an access-inhibit flag.

Top module: `lp_mode_ctrl`

## Requirements
- R1: While reset is applied, and for a window after it, `mode_o` is 0 (init), `ready_o` is 0 and `access_inhibit_o` is 1. Reset release passes through a two-stage synchronizer. The first non-init mode appears in the cycle that follows clock edge number 3 + INIT_US*CLK_PER_US, counting from the release.
- R2: Outside init and the low-power modes, `mode_o` is 1 (active) when `ce_n` is 0 and 2 (standby) when `ce_n` is 1. In both of these, `ready_o` = 1 and `access_inhibit_o` = 0.
- R3: A low-power mode is entered only if `sleep_req_n` is sampled 0 on more than ENTRY_US*CLK_PER_US consecutive clock edges. The mode changes on edge ENTRY_US*CLK_PER_US, where the first low edge is edge 0. A shorter low pulse leaves the mode unchanged, and the count restarts at the next low pulse.
- R4: On qualified entry, `cfg_partial` = 1 selects partial refresh (mode 3) and `cfg_partial` = 0 selects deep power-down (mode 4).
- R5: In modes 3 and 4, `access_inhibit_o` = 1. `ready_o` is 1 in mode 3 and 0 in mode 4.
- R6: Without the lock, `sleep_req_n` = 1 in mode 3 moves the block to mode 1 or mode 2 (per `ce_n`) on the next edge.
- R7: `sleep_req_n` = 1 in mode 4 moves the block to mode 0 on the next edge. Mode 0 then lasts until INIT_US*CLK_PER_US + 1 further edges have passed, after which mode 1 or mode 2 follows.
- R8: A one-cycle `sw_cfg_load` pulse sets a lock that only reset clears. While locked, mode 3 is entered from mode 1 or 2 on the second edge after the pulse whenever `cfg_partial` = 1, whatever the pin does. While locked, `sleep_req_n` = 1 does not leave mode 3, and mode 3 is left on the next edge once `cfg_partial` = 0.
- R9: While locked with `cfg_partial` = 0, a qualified low pin still enters mode 4.
- R10: `ce_n` activity during mode 0 does not change the length of the init window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| sleep_req_n | input | 1 | Active-low sleep request pin |
| ce_n | input | 1 | Active-low chip enable |
| cfg_partial | input | 1 | Sleep-mode bit: 1 selects partial refresh, 0 selects deep power-down |
| sw_cfg_load | input | 1 | One-cycle pulse: configuration register loaded by the software sequence |
| mode_o | output | 3 | Mode code: 0 init, 1 active, 2 standby, 3 partial refresh, 4 deep power-down |
| ready_o | output | 1 | Array usable (not init, not deep power-down) |
| access_inhibit_o | output | 1 | Reads and writes must be ignored |

## Verification
The embedded properties check several rules on every cycle. No low-power entry may happen before the timer reaches the qualifying count. The mode picked on entry must match the selection bit. Pin-driven exits from both low-power modes must take effect within one cycle. The init window may not be cut short, the lock may never drop, and the microsecond count must saturate and step by at most one. Only the bench scenarios can show the exact cycle counts. It sweeps low-pulse lengths on both sides of the threshold for each mode bit and chip-enable level, measures the init length after reset and after deep power-down, and walks through the lock sequence and its clearing by reset.

// File: rtl/lp_mode_pkg.sv
package lp_mode_pkg;

  typedef enum logic [2:0] {
    PM_INIT     = 3'd0,
    PM_ACTIVE   = 3'd1,
    PM_STANDBY  = 3'd2,
    PM_PARTIAL  = 3'd3,
    PM_DEEPDOWN = 3'd4
  } pm_state_e;

  function automatic logic pm_is_awake(input pm_state_e s);
    return (s == PM_ACTIVE) || (s == PM_STANDBY);
  endfunction

endpackage

// File: rtl/lp_rst_sync.sv
module lp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_n_sync = stage2_q;
endmodule

// File: rtl/lp_us_timer.sv
module lp_us_timer #(
  parameter int CLK_PER_US = 100,
  parameter int MAX_US     = 150,
  parameter int UW         = $clog2(MAX_US + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  output logic [UW-1:0] us_cnt
);
  localparam int CW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [CW-1:0] CYC_LAST = CW'(CLK_PER_US - 1);
  localparam logic [UW-1:0] US_TOP   = UW'(MAX_US);

  logic [CW-1:0] cyc_q, cyc_d;
  logic [UW-1:0] us_q, us_d;
  logic          cyc_en, us_en, tick;

  assign tick   = (cyc_q == CYC_LAST);
  assign cyc_en = 1'b1;
  assign us_en  = clr || (tick && (us_q != US_TOP));

  always_comb begin
    cyc_d = cyc_q;
    us_d  = us_q;
    if (clr) begin
      cyc_d = '0;
      us_d  = '0;
    end else begin
      cyc_d = tick ? '0 : cyc_q + 1'b1;
      if (tick && (us_q != US_TOP)) us_d = us_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q <= '0;
      us_q  <= '0;
    end else begin
      if (cyc_en) cyc_q <= cyc_d;
      if (us_en)  us_q  <= us_d;
    end
  end

  assign us_cnt = us_q;

  AST_US_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    us_q <= US_TOP); // R3
  AST_US_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (us_q == $past(us_q)) || (us_q == $past(us_q) + 1'b1)); // R3
endmodule

// File: rtl/lp_mode_fsm.sv
module lp_mode_fsm
  import lp_mode_pkg::*;
#(
  parameter int ENTRY_US = 10,
  parameter int INIT_US  = 150,
  parameter int UW       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sleep_n,
  input  logic          ce_n,
  input  logic          cfg_partial,
  input  logic          sw_cfg_load,
  input  logic [UW-1:0] us_cnt,
  output pm_state_e     state,
  output logic          tmr_clr
);
  localparam logic [UW-1:0] ENTRY_LIM = UW'(ENTRY_US);
  localparam logic [UW-1:0] INIT_LIM  = UW'(INIT_US);

  pm_state_e state_q, state_d;
  logic      lock_q, lock_d, lock_en;
  pm_state_e awake_st;

  assign awake_st = ce_n ? PM_STANDBY : PM_ACTIVE;
  assign lock_en  = sw_cfg_load;
  assign lock_d   = 1'b1;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PM_INIT: begin
        if (us_cnt >= INIT_LIM) state_d = awake_st;
      end
      PM_ACTIVE, PM_STANDBY: begin
        if (lock_q && cfg_partial)                  state_d = PM_PARTIAL;
        else if (!sleep_n && (us_cnt >= ENTRY_LIM)) state_d = cfg_partial ? PM_PARTIAL : PM_DEEPDOWN;
        else                                        state_d = awake_st;
      end
      PM_PARTIAL: begin
        if (lock_q) state_d = cfg_partial ? PM_PARTIAL : awake_st;
        else        state_d = sleep_n ? awake_st : PM_PARTIAL;
      end
      PM_DEEPDOWN: begin
        if (sleep_n) state_d = PM_INIT;
      end
      default: state_d = PM_INIT;
    endcase
  end

  always_comb begin
    tmr_clr = (pm_is_awake(state_q) && sleep_n) ||
              ((state_d != state_q) && !(pm_is_awake(state_q) && pm_is_awake(state_d)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PM_INIT;
      lock_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (lock_en) lock_q <= lock_d;
    end
  end

  assign state = state_q;

  AST_NO_EARLY_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_is_awake(state_q) && (us_cnt < ENTRY_LIM) && !(lock_q && cfg_partial))
      |=> !(state_q inside {PM_PARTIAL, PM_DEEPDOWN})); // R3
  AST_ENTRY_MODE_PICK: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_is_awake(state_q) && !sleep_n && !lock_q && (us_cnt >= ENTRY_LIM))
      |=> (state_q == (($past(cfg_partial)) ? PM_PARTIAL : PM_DEEPDOWN))); // R4
  AST_PARTIAL_PIN_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_PARTIAL && sleep_n && !lock_q) |=> pm_is_awake(state_q)); // R6
  AST_DEEP_EXIT_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_DEEPDOWN && sleep_n) |=> (state_q == PM_INIT)); // R7
  AST_INIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_INIT && us_cnt < INIT_LIM) |=> (state_q == PM_INIT)); // R1
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q); // R8
endmodule

// File: rtl/lp_mode_ctrl.sv
module lp_mode_ctrl
  import lp_mode_pkg::*;
#(
  parameter int CLK_PER_US = 100,
  parameter int ENTRY_US   = 10,
  parameter int INIT_US    = 150
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleep_req_n,
  input  logic       ce_n,
  input  logic       cfg_partial,
  input  logic       sw_cfg_load,
  output logic [2:0] mode_o,
  output logic       ready_o,
  output logic       access_inhibit_o
);
  localparam int MAX_US = (INIT_US > ENTRY_US) ? INIT_US : ENTRY_US;
  localparam int UW     = $clog2(MAX_US + 1);

  logic          rst_int_n;
  logic          tmr_clr;
  logic [UW-1:0] us_cnt;
  pm_state_e     state;

  lp_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_int_n)
  );

  lp_us_timer #(.CLK_PER_US(CLK_PER_US), .MAX_US(MAX_US), .UW(UW)) u_timer (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .clr    (tmr_clr),
    .us_cnt (us_cnt)
  );

  lp_mode_fsm #(.ENTRY_US(ENTRY_US), .INIT_US(INIT_US), .UW(UW)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .sleep_n     (sleep_req_n),
    .ce_n        (ce_n),
    .cfg_partial (cfg_partial),
    .sw_cfg_load (sw_cfg_load),
    .us_cnt      (us_cnt),
    .state       (state),
    .tmr_clr     (tmr_clr)
  );

  assign mode_o           = state;
  assign ready_o          = (state != PM_INIT) && (state != PM_DEEPDOWN);
  assign access_inhibit_o = !pm_is_awake(state);

  AST_DEEP_NOT_READY: assert property (@(posedge clk) disable iff (!rst_int_n)
    ($past(state) == PM_DEEPDOWN && !$past(sleep_req_n)) |-> !ready_o); // R5
endmodule

// File: tb/lp_mode_ctrl_tb.sv
module lp_mode_ctrl_tb_top;
  localparam int P     = 4;
  localparam int ENT   = 2;
  localparam int INI   = 3;
  localparam int THR   = ENT * P + 1;

  logic clk = 1'b0;
  logic rst_n, sleep_req_n, ce_n, cfg_partial, sw_cfg_load;
  logic [2:0] mode_o;
  logic ready_o, access_inhibit_o;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lp_mode_ctrl #(.CLK_PER_US(P), .ENTRY_US(ENT), .INIT_US(INI)) dut_i (
    .clk(clk), .rst_n(rst_n), .sleep_req_n(sleep_req_n), .ce_n(ce_n),
    .cfg_partial(cfg_partial), .sw_cfg_load(sw_cfg_load),
    .mode_o(mode_o), .ready_o(ready_o), .access_inhibit_o(access_inhibit_o)
  );

  task automatic chk(input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic wait_init(input int exp_len, input bit wiggle, input string what);
    int n = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      n++;
      if (wiggle) ce_n = ~ce_n;
      if (mode_o != 3'd0) break;
    end
    chk(n, exp_len, what);
  endtask

  task automatic do_reset(input bit wiggle);
    rst_n = 1'b0; sleep_req_n = 1'b1; ce_n = 1'b1; cfg_partial = 1'b1; sw_cfg_load = 1'b0;
    repeat (3) @(negedge clk);
    chk(int'(mode_o), 0, "R1 mode in reset");
    chk(int'(ready_o), 0, "R1 ready in reset");
    chk(int'(access_inhibit_o), 1, "R1 inhibit in reset");
    rst_n = 1'b1;
    wait_init(3 + INI * P, wiggle, wiggle ? "R10 init length with ce_n toggling" : "R1 init length");
    ce_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    do_reset(1'b0);
    chk(int'(mode_o), 2, "R2 standby");
    chk(int'(access_inhibit_o), 0, "R2 inhibit in standby");
    ce_n = 1'b0; @(negedge clk);
    chk(int'(mode_o), 1, "R2 active");
    chk(int'(ready_o), 1, "R2 ready in active");

    for (int cfg = 0; cfg < 2; cfg++) begin
      for (int ce = 0; ce < 2; ce++) begin
        for (int len = 1; len <= THR + 3; len++) begin
          int base;
          int lp;
          base = (ce != 0) ? 2 : 1;
          lp   = (cfg != 0) ? 3 : 4;
          cfg_partial = 1'(cfg); ce_n = 1'(ce);
          repeat (2) @(negedge clk);
          sleep_req_n = 1'b0;
          repeat (len) @(negedge clk);
          // R3/R4: entry only past the threshold, mode picked by cfg_partial
          chk(int'(mode_o), (len >= THR) ? lp : base, $sformatf("R3 R4 after low of %0d cycles", len));
          if (len >= THR) begin
            chk(int'(access_inhibit_o), 1, "R5 inhibit in low-power");
            chk(int'(ready_o), (cfg != 0) ? 1 : 0, "R5 ready in low-power");
          end
          sleep_req_n = 1'b1;
          if (len >= THR && cfg != 0) begin
            @(negedge clk);
            chk(int'(mode_o), base, "R6 partial exit");
          end else if (len >= THR) begin
            @(negedge clk);
            chk(int'(mode_o), 0, "R7 deep exit to init");
            wait_init(INI * P + 1, 1'b0, "R7 init after deep exit");
            chk(int'(mode_o), base, "R7 awake after init");
          end else begin
            @(negedge clk);
            chk(int'(mode_o), base, "R3 short pulse ignored");
          end
        end
      end
    end

    // R8: software lock
    ce_n = 1'b1; cfg_partial = 1'b1;
    @(negedge clk);
    sw_cfg_load = 1'b1; @(negedge clk); sw_cfg_load = 1'b0;
    chk(int'(mode_o), 2, "R8 one edge after load");
    @(negedge clk);
    chk(int'(mode_o), 3, "R8 partial forced by lock");
    repeat (5) @(negedge clk);
    chk(int'(mode_o), 3, "R8 pin high does not exit while locked");
    cfg_partial = 1'b0; @(negedge clk);
    chk(int'(mode_o), 2, "R8 leave partial when bit cleared");
    // R9: deep entry still pin-driven while locked
    sleep_req_n = 1'b0;
    repeat (THR) @(negedge clk);
    chk(int'(mode_o), 4, "R9 deep entry while locked");
    sleep_req_n = 1'b1;
    @(negedge clk);
    wait_init(INI * P + 1, 1'b0, "R9 init after deep exit");
    cfg_partial = 1'b1; @(negedge clk); @(negedge clk);
    chk(int'(mode_o), 3, "R8 lock kept across deep power-down");

    // R8: reset clears the lock, R10: ce_n ignored during init
    do_reset(1'b1);
    chk(int'(mode_o), 2, "R8 no lock after reset");
    sleep_req_n = 1'b0;
    repeat (THR) @(negedge clk);
    chk(int'(mode_o), 3, "R8 pin partial entry after reset");
    sleep_req_n = 1'b1; @(negedge clk);
    chk(int'(mode_o), 2, "R8 pin exit after reset");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule